// File: doc/BRIEF.md
# Store Queue Ordering Unit

This block stands between one core's memory pipeline and its first-level data cache and decides which request reaches the cache in each cycle. Stores never go straight to the cache. They are written into a small first-in first-out store queue. The oldest queued store is then offered to the cache whenever the cache port is not needed by the core. Loads do not wait for that queue. A load whose word address matches a queued store takes its data from the youngest such store and is answered one cycle later on a forwarding output. Any other load is sent to the cache at once, and store drain yields the port to it for that cycle.

Load-reserved and store-conditional requests, fences and undefined operation codes are held at the request port until the store queue is empty. This keeps atomic accesses and fences ordered after every earlier store. Fences and undefined codes are consumed without a cache access. The core-side request uses a valid/ready pair: a request is taken on a clock edge where both are high, and the core must keep it stable until then. The cache-side port is offered again every cycle. `cache_valid` and its fields describe the winner of that cycle's arbitration, and a transfer happens on an edge where `cache_valid` and `cache_ready` are both high. A pending store drain may be displaced by a load in the next cycle and offered again afterwards, so the cache must not assume that an offer is held.

Operation encoding on `req_op` and `cache_op`: 0 load, 1 store, 2 load-reserved, 3 store-conditional, 4 fence. Codes 5 to 7 behave like a fence.

Top module: `store_order_unit`

## Requirements
- R1: After reset, `cache_valid` and `fwd_valid` are 0 and the store queue is empty: a load-reserved request (code 2) with `cache_ready` high is accepted at once.
- R2: A store (code 1) is accepted whenever fewer than DEPTH stores are queued, whatever `cache_ready` is. It never appears on the cache port in the cycle it is accepted, and with an empty queue `cache_valid` stays 0 in that cycle.
- R3: Queued stores are offered to the cache oldest first, with `cache_op`=1 and the stored address and data. One store leaves the queue on each edge where it is offered and `cache_ready` is high. Stores are never lost or reordered.
- R4: A load (code 0) with no matching queued word address is offered to the cache in the same cycle with `cache_op`=0 and its address, even while stores are queued. `req_ready` equals `cache_ready` for such a load.
- R5: A load whose address equals a queued store's address is accepted with `req_ready`=1 and takes no cache cycle. In the next cycle `fwd_valid` is 1 and `fwd_data` holds the data of the youngest matching store. `fwd_valid` is 0 in every other cycle.
- R6: Load-reserved (2) and store-conditional (3) requests see `req_ready`=0 while any store is queued. With an empty queue they are offered to the cache with their own code and address, and `req_ready` equals `cache_ready`.
- R7: Fence (4) and undefined codes (5 to 7) are accepted only when the queue is empty, and never reach the cache port.
- R8: With DEPTH stores queued, `req_ready` for a store is 0, even if a drain completes in the same cycle.
- R9: At most one request is offered per cycle, and a cache-bound load wins over store drain. A non-empty queue offers its oldest store in every cycle in which no core request needs the port, including cycles with a forwarded load or a held atomic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request taken on this edge |
| req_op | input | 3 | Operation code (0 load, 1 store, 2 LR, 3 SC, 4 fence) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Store or conditional-store data |
| cache_valid | output | 1 | Request offered to the cache this cycle |
| cache_ready | input | 1 | Cache takes the offered request |
| cache_op | output | 3 | Operation code of the offered request |
| cache_addr | output | ADDR_W | Address of the offered request |
| cache_data | output | DATA_W | Data of the offered request |
| fwd_valid | output | 1 | Forwarded load result valid |
| fwd_data | output | DATA_W | Forwarded load data |

## Verification
A corrupted queue pointer or occupancy count becomes visible on the cache port within one cycle. Either the drained address and data stop following the order in which stores were accepted, or the readiness of atomics, fences and stores stops tracking how many stores are outstanding. A wrong age order in the match logic shows up in the cycle after a load as a forwarded value from an older store rather than the youngest one. A wrong arbitration choice shows up combinationally in the same cycle as a store on the port while a missing load waits.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LRES  = 3'd2,
    OP_SCOND = 3'd3,
    OP_FENCE = 3'd4
  } mem_op_e;

  function automatic logic op_is_atomic(input logic [2:0] op);
    return (op == OP_LRES) || (op == OP_SCOND);
  endfunction

  function automatic logic op_is_barrier(input logic [2:0] op);
    return op >= OP_FENCE;
  endfunction
endpackage

// File: rtl/sq_fifo.sv
module sq_fifo #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] age_addr  [DEPTH],
  output logic [DATA_W-1:0] age_data  [DEPTH],
  output logic              age_valid [DEPTH]
);
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[wr_ptr] <= push_addr;
      slot_data[wr_ptr] <= push_data;
    end
  end

  // age 0 is the oldest entry, age count-1 the youngest
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0] idx;
    assign idx          = rd_ptr + PTR_W'(k);
    assign age_addr[k]  = slot_addr[idx];
    assign age_data[k]  = slot_data[idx];
    assign age_valid[k] = CNT_W'(k) < count;
  end
endmodule

// File: rtl/sq_fwd_match.sv
module sq_fwd_match #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic [ADDR_W-1:0] look_addr,
  input  logic [ADDR_W-1:0] age_addr  [DEPTH],
  input  logic [DATA_W-1:0] age_data  [DEPTH],
  input  logic              age_valid [DEPTH],
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);
  logic [DEPTH-1:0] match;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign match[k] = age_valid[k] && (age_addr[k] == look_addr);
  end

  // scan oldest to youngest so the youngest match overwrites
  always_comb begin
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (match[k]) hit_data = age_data[k];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/sq_dispatch.sv
module sq_dispatch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              fwd_hit,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  input  logic              cache_ready,
  output logic              req_ready,
  output logic              push,
  output logic              pop,
  output logic              fwd_take,
  output logic              cache_valid,
  output logic [2:0]        cache_op,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [DATA_W-1:0] cache_data
);
  import sq_pkg::*;

  logic q_empty, q_full;
  logic is_load, is_store, is_atomic, is_barrier;
  logic load_to_cache, atomic_to_cache, core_to_cache, drain_offer;

  assign q_empty = (count == '0);
  assign q_full  = (count == CNT_W'(DEPTH));

  assign is_load    = (req_op == OP_LOAD);
  assign is_store   = (req_op == OP_STORE);
  assign is_atomic  = op_is_atomic(req_op);
  assign is_barrier = op_is_barrier(req_op);

  assign load_to_cache   = req_valid && is_load && !fwd_hit;
  assign atomic_to_cache = req_valid && is_atomic && q_empty;
  assign core_to_cache   = load_to_cache || atomic_to_cache;
  assign drain_offer     = !q_empty && !core_to_cache;

  always_comb begin
    req_ready = 1'b0;
    if (is_load)         req_ready = fwd_hit ? 1'b1 : cache_ready;
    else if (is_store)   req_ready = !q_full;
    else if (is_atomic)  req_ready = q_empty && cache_ready;
    else if (is_barrier) req_ready = q_empty;
  end

  assign push     = req_valid && is_store && !q_full;
  assign pop      = drain_offer && cache_ready;
  assign fwd_take = req_valid && is_load && fwd_hit;

  assign cache_valid = core_to_cache || drain_offer;

  always_comb begin
    if (core_to_cache) begin
      cache_op   = req_op;
      cache_addr = req_addr;
      cache_data = req_data;
    end else begin
      cache_op   = OP_STORE;
      cache_addr = head_addr;
      cache_data = head_data;
    end
  end
endmodule

// File: rtl/store_order_unit.sv
module store_order_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              cache_valid,
  input  logic              cache_ready,
  output logic [2:0]        cache_op,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [DATA_W-1:0] cache_data,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data
);
  logic [CNT_W-1:0]  sq_count;
  logic [ADDR_W-1:0] age_addr  [DEPTH];
  logic [DATA_W-1:0] age_data  [DEPTH];
  logic              age_valid [DEPTH];
  logic              push, pop, fwd_take, fwd_hit;
  logic [DATA_W-1:0] hit_data;

  sq_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_data),
    .pop       (pop),
    .count     (sq_count),
    .age_addr  (age_addr),
    .age_data  (age_data),
    .age_valid (age_valid)
  );

  sq_fwd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .look_addr (req_addr),
    .age_addr  (age_addr),
    .age_data  (age_data),
    .age_valid (age_valid),
    .hit       (fwd_hit),
    .hit_data  (hit_data)
  );

  sq_dispatch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dispatch (
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .fwd_hit     (fwd_hit),
    .count       (sq_count),
    .head_addr   (age_addr[0]),
    .head_data   (age_data[0]),
    .cache_ready (cache_ready),
    .req_ready   (req_ready),
    .push        (push),
    .pop         (pop),
    .fwd_take    (fwd_take),
    .cache_valid (cache_valid),
    .cache_op    (cache_op),
    .cache_addr  (cache_addr),
    .cache_data  (cache_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= fwd_take;
      if (fwd_take) fwd_data <= hit_data;
    end
  end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic             cache_valid,
  input logic             cache_ready,
  input logic [2:0]       cache_op,
  input logic             fwd_valid,
  input logic [CNT_W-1:0] sq_count
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sq_count <= CNT_W'(DEPTH)) else $error("count above depth"); // R2

  AST_DRAIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && cache_op == 3'd1) |-> (sq_count != '0)) else $error("drain from empty"); // R3

  AST_LOAD_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && cache_ready) |-> req_ready) else $error("load stalled"); // R4

  AST_FWD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(req_valid && req_ready && req_op == 3'd0)) else $error("spurious forward"); // R5

  AST_ATOMIC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && (cache_op == 3'd2 || cache_op == 3'd3)) |-> (sq_count == '0)) else $error("atomic early"); // R6

  AST_BARRIER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op >= 3'd4 && sq_count != '0) |-> !req_ready) else $error("fence early"); // R7

  AST_BARRIER_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid |-> (cache_op < 3'd4)) else $error("fence on port"); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && sq_count == CNT_W'(DEPTH)) |-> !req_ready) else $error("overflow"); // R8
endmodule

bind store_order_unit sq_checker #(.DEPTH(DEPTH)) u_sq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .cache_valid (cache_valid),
  .cache_ready (cache_ready),
  .cache_op    (cache_op),
  .fwd_valid   (fwd_valid),
  .sq_count    (sq_count)
);

// File: tb/test_store_order_unit.sv
`timescale 1ns/1ps
module test_store_order_unit;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          cache_valid;
  logic          cache_ready = 1'b0;
  logic [2:0]    cache_op;
  logic [AW-1:0] cache_addr;
  logic [DW-1:0] cache_data;
  logic          fwd_valid;
  logic [DW-1:0] fwd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  store_order_unit #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_store_order_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_op(cache_op),
    .cache_addr(cache_addr), .cache_data(cache_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic cr);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_data = d; cache_ready = cr;
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; cache_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // fill with n stores at 0x20+k, data 0x100+k, cache never ready
  task automatic fill(input int n);
    for (int k = 0; k < n; k++) drive(1'b1, 3'd1, AW'(8'h20 + k), DW'(16'h100 + k), 1'b0);
    drive(1'b0, 3'd0, '0, '0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] qd [$];
    logic [AW-1:0] qa [$];
    do_reset();
    drive(1'b1, 3'd2, 8'h33, '0, 1'b1);
    chk("R1 cache_valid after reset is LR offer", {31'd0, cache_valid}, 32'd1);
    chk("R1 LR ready on empty queue", {31'd0, req_ready}, 32'd1);
    chk("R1 fwd_valid after reset", {31'd0, fwd_valid}, 32'd0);
    drive(1'b0, 3'd0, '0, '0, 1'b0);

    // combinational sweep: queue occupancy x op code x cache_ready x hit
    for (int cnt = 0; cnt <= DEPTH; cnt++) begin
      do_reset();
      fill(cnt);
      for (int op = 0; op < 8; op++) begin
        for (int cr = 0; cr < 2; cr++) begin
          for (int h = 0; h < 2; h++) begin
            logic [AW-1:0] a;
            logic er, ev, hit, empty, full;
            logic [2:0] eop;
            logic [AW-1:0] ea;
            if (h == 1 && (cnt == 0 || op != 0)) continue;
            hit = (h == 1);
            empty = (cnt == 0);
            full = (cnt == DEPTH);
            a = hit ? AW'(8'h20 + cnt - 1) : 8'h80;
            @(negedge clk);
            req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_data = 16'hBEEF;
            cache_ready = cr[0];
            #1;
            case (op)
              0: er = hit ? 1'b1 : cr[0];
              1: er = !full;
              2, 3: er = empty && cr[0];
              default: er = empty;
            endcase
            ev = (op == 0 && !hit) || ((op == 2 || op == 3) && empty) || !empty;
            if (op == 0 && !hit) begin eop = 3'd0; ea = a; end
            else if ((op == 2 || op == 3) && empty) begin eop = 3'(op); ea = a; end
            else begin eop = 3'd1; ea = 8'h20; end
            case (op)
              0: chk("R4 R5 R9 load ready", {31'd0, req_ready}, {31'd0, er});
              1: chk("R2 R8 store ready", {31'd0, req_ready}, {31'd0, er});
              2, 3: chk("R6 atomic ready", {31'd0, req_ready}, {31'd0, er});
              default: chk("R7 fence ready", {31'd0, req_ready}, {31'd0, er});
            endcase
            chk("R9 cache_valid", {31'd0, cache_valid}, {31'd0, ev});
            if (ev) begin
              chk("R9 cache_op", {29'd0, cache_op}, {29'd0, eop});
              chk("R9 cache_addr", {24'd0, cache_addr}, {24'd0, ea});
              if (eop == 3'd1) chk("R3 drain data", {16'd0, cache_data}, 32'h100);
            end
            req_valid = 1'b0; cache_ready = 1'b0;
          end
        end
      end
    end

    // forwarding with a duplicated address: youngest wins
    do_reset();
    drive(1'b1, 3'd1, 8'h10, 16'h1111, 1'b0); qa.push_back(8'h10); qd.push_back(16'h1111);
    drive(1'b1, 3'd1, 8'h14, 16'h2222, 1'b0); qa.push_back(8'h14); qd.push_back(16'h2222);
    drive(1'b1, 3'd1, 8'h10, 16'h3333, 1'b0); qa.push_back(8'h10); qd.push_back(16'h3333);
    drive(1'b1, 3'd1, 8'h18, 16'h4444, 1'b0); qa.push_back(8'h18); qd.push_back(16'h4444);
    drive(1'b1, 3'd1, 8'h1C, 16'h5555, 1'b0);
    chk("R8 store refused when full", {31'd0, req_ready}, 32'd0);
    begin
      logic [AW-1:0] la [3] = '{8'h10, 8'h14, 8'h18};
      logic [DW-1:0] ld [3] = '{16'h3333, 16'h2222, 16'h4444};
      for (int i = 0; i < 3; i++) begin
        drive(1'b1, 3'd0, la[i], '0, 1'b0);
        chk("R5 forwarded load ready", {31'd0, req_ready}, 32'd1);
        chk("R9 drain offered beside forwarded load", {29'd0, cache_op}, 32'd1);
        drive(1'b0, 3'd0, '0, '0, 1'b0);
        chk("R5 fwd_valid next cycle", {31'd0, fwd_valid}, 32'd1);
        chk("R5 youngest match data", {16'd0, fwd_data}, {16'd0, ld[i]});
      end
    end
    drive(1'b1, 3'd0, 8'h40, '0, 1'b1);
    chk("R4 miss load on port with queue full", {29'd0, cache_op}, 32'd0);
    chk("R4 miss load ready", {31'd0, req_ready}, 32'd1);
    drive(1'b0, 3'd0, '0, '0, 1'b1);
    chk("R5 no forward after miss load", {31'd0, fwd_valid}, 32'd0);
    // this cycle pops the oldest store
    chk("R3 oldest store resumes after load", {24'd0, cache_addr}, {24'd0, qa[0]});
    chk("R3 oldest data", {16'd0, cache_data}, {16'd0, qd[0]});
    void'(qa.pop_front()); void'(qd.pop_front());
    while (qa.size() > 0) begin
      drive(1'b0, 3'd0, '0, '0, 1'b1);
      chk("R3 drain valid", {31'd0, cache_valid}, 32'd1);
      chk("R3 drain op", {29'd0, cache_op}, 32'd1);
      chk("R3 drain addr order", {24'd0, cache_addr}, {24'd0, qa[0]});
      chk("R3 drain data order", {16'd0, cache_data}, {16'd0, qd[0]});
      void'(qa.pop_front()); void'(qd.pop_front());
    end
    drive(1'b0, 3'd0, '0, '0, 1'b1);
    chk("R3 idle once drained", {31'd0, cache_valid}, 32'd0);
    drive(1'b1, 3'd3, 8'h44, 16'h7777, 1'b1);
    chk("R6 SC after drain ready", {31'd0, req_ready}, 32'd1);
    chk("R6 SC op on port", {29'd0, cache_op}, 32'd3);
    chk("R6 SC data on port", {16'd0, cache_data}, 32'h7777);
    drive(1'b1, 3'd7, 8'h44, '0, 1'b1);
    chk("R7 undefined code accepted when empty", {31'd0, req_ready}, 32'd1);
    chk("R7 undefined code not on port", {31'd0, cache_valid}, 32'd0);
    drive(1'b0, 3'd0, '0, '0, 1'b0);
    chk("R7 queue still empty after undefined code", {31'd0, cache_valid}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule